// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns parallel bytes into an asynchronous serial character stream. A byte is captured into a holding buffer when the active-low load strobe is sampled low. From there it moves into a shift register and is sent on the serial line in a fixed order: a low start bit, then 5 to 8 data bits starting with bit 0, then an optional parity bit, then the stop interval. The block runs on a single clock at 16 times the bit rate, so each bit is held for 16 clocks. Because there is a holding buffer in front of the shifter, software can write the next byte while the current one is still going out, and characters can follow one another with no idle gap.

The character format has three parts: the data length, the parity mode and the stop length. All three are sampled into a format register only when the format strobe is high. Each character takes its format from that register at the moment it enters the shifter, so a format change never alters a character that is already being sent. Two registered status flags are provided. One shows that the holding buffer is free. The other shows that the shifter has finished, including the whole stop interval.

Top module: `uart_tx_core`

## Requirements
- R1: A synchronous active-high reset drives txd high and sets buf_empty and shift_empty high. It also returns the format register to 8 data bits, no parity and one stop bit.
- R2: When load_n is sampled low at a rising edge, din is captured into the holding buffer, and buf_empty reads low after that edge.
- R3: When the shifter is idle and the buffer is full, the buffer moves into the shifter on the next edge. After that edge txd is low (start bit), buf_empty is high and shift_empty is low.
- R4: Every bit on txd is held for exactly 16 clocks. Data bits go out least significant bit first. len_sel selects the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8.
- R5: With par_off high, no parity bit is sent. With par_off low, one parity bit follows the data. If par_even is high, the parity bit makes the count of ones in the data plus parity even. If par_even is low, it makes that count odd.
- R6: With stop_two low, the stop interval is 16 clocks. With stop_two high, it is 32 clocks, except with 5-bit data, where it is 24 clocks.
- R7: shift_empty goes high one clock after the last stop clock when the buffer is empty. While shift_empty is high, txd is high.
- R8: If the buffer is full when a character's last stop clock ends, the next start bit follows at once. In that case shift_empty stays low and buf_empty goes high.
- R9: len_sel, par_off, par_even and stop_two have no effect unless fmt_load is sampled high. A format loaded while a character is being sent does not change that character, and it applies from the next character onward.
- R10: din bits above the selected data length are neither sent nor included in the parity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock, 16 times the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| fmt_load | input | 1 | Format strobe, active high |
| len_sel | input | 2 | Data length code |
| par_off | input | 1 | High to send no parity bit |
| par_even | input | 1 | High selects even parity, low selects odd |
| stop_two | input | 1 | High selects the long stop interval |
| load_n | input | 1 | Buffer load strobe, active low |
| din | input | 8 | Parallel data byte |
| txd | output | 1 | Serial output, idles high |
| buf_empty | output | 1 | Holding buffer is free |
| shift_empty | output | 1 | Shifter is idle |

## Verification
Let the load edge be the rising edge at which load_n is sampled low. buf_empty is due low one edge after the load edge. When the shifter is idle, the start bit and the change on both flags are due one edge after that. Clock k of the character, counted from 0, shows bit floor(k/16) of the expected frame. shift_empty is due high exactly one edge after the last of the frame's clocks, whose count the bench works out from the length, parity and stop settings. The bench drives inputs and samples outputs only on falling edges, and it counts edges from each load to compare every clock of every frame against a sequence it builds itself from the requirements.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef struct packed {
    logic [1:0] len;
    logic       par_en;
    logic       par_even;
    logic       stop_two;
  } tx_fmt_t;

  localparam tx_fmt_t FMT_RESET = '{len: 2'b11, par_en: 1'b0, par_even: 1'b0, stop_two: 1'b0};
endpackage

// File: rtl/tx_fmt_reg.sv
module tx_fmt_reg
  import uart_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       fmt_load,
  input  logic [1:0] len_sel,
  input  logic       par_off,
  input  logic       par_even,
  input  logic       stop_two,
  output tx_fmt_t    fmt_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fmt_q <= FMT_RESET;
    end else if (fmt_load) begin
      fmt_q.len      <= len_sel;
      fmt_q.par_en   <= ~par_off;
      fmt_q.par_even <= par_even;
      fmt_q.stop_two <= stop_two;
    end
  end
endmodule

// File: rtl/tx_buffer.sv
module tx_buffer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_n,
  input  logic [DATA_W-1:0] din,
  input  logic              take,
  output logic [DATA_W-1:0] buf_q,
  output logic              buf_empty_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q       <= '0;
      buf_empty_q <= 1'b1;
    end else begin
      if (!load_n) buf_q <= din;
      if (!load_n)   buf_empty_q <= 1'b0;
      else if (take) buf_empty_q <= 1'b1;
    end
  end

  // R2
  load_sets_full_chk: assert property (@(posedge clk) disable iff (rst)
    !load_n |=> !buf_empty_q);

  // R3
  empty_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(buf_empty_q) |-> $past(take));
endmodule

// File: rtl/tx_frame_pack.sv
module tx_frame_pack
  import uart_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MIN_LEN = 5,
  parameter int OS      = 16,
  parameter int FRAME_W = DATA_W + 2,
  parameter int CNT_W   = $clog2(OS * (DATA_W + 4) + 1)
) (
  input  tx_fmt_t           fmt,
  input  logic [DATA_W-1:0] data,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]  ticks
);
  int   dlen;
  int   nbits;
  int   stop_t;
  logic par;
  logic pbit;

  always_comb begin
    dlen = MIN_LEN + int'(fmt.len);
    par  = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (i < dlen) par = par ^ data[i];
    pbit = fmt.par_even ? par : ~par;

    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < dlen)                     frame[i+1] = data[i];
      else if (i == dlen && fmt.par_en) frame[i+1] = pbit;
    end
    if (dlen == DATA_W && fmt.par_en) frame[DATA_W+1] = pbit;

    nbits  = 1 + dlen + (fmt.par_en ? 1 : 0);
    stop_t = !fmt.stop_two ? OS : ((dlen == MIN_LEN) ? OS + OS / 2 : 2 * OS);
    ticks  = CNT_W'(OS * nbits + stop_t);
  end
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter #(
  parameter int FRAME_W = 10,
  parameter int OS      = 16,
  parameter int CNT_W   = 8,
  parameter int SUB_W   = $clog2(OS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               buf_full,
  input  logic [FRAME_W-1:0] frame,
  input  logic [CNT_W-1:0]   ticks,
  output logic               take,
  output logic               txd,
  output logic               shift_empty
);
  logic [FRAME_W-1:0] sr_q;
  logic [CNT_W-1:0]   left_q;
  logic [SUB_W-1:0]   sub_q;
  logic               idle_q;
  logic               fin;

  assign fin  = !idle_q && (left_q == '0);
  assign take = buf_full && (idle_q || fin);

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q   <= '1;
      left_q <= '0;
      sub_q  <= '0;
      idle_q <= 1'b1;
    end else if (take) begin
      sr_q   <= frame;
      left_q <= ticks - CNT_W'(1);
      sub_q  <= '0;
      idle_q <= 1'b0;
    end else if (fin) begin
      sr_q   <= '1;
      sub_q  <= '0;
      idle_q <= 1'b1;
    end else if (!idle_q) begin
      left_q <= left_q - CNT_W'(1);
      if (sub_q == SUB_W'(OS - 1)) begin
        sub_q <= '0;
        sr_q  <= {1'b1, sr_q[FRAME_W-1:1]};
      end else begin
        sub_q <= sub_q + SUB_W'(1);
      end
    end
  end

  assign txd         = sr_q[0];
  assign shift_empty = idle_q;

  // R3
  start_on_take_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> (!txd && !shift_empty));

  // R7
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    shift_empty |-> txd);

  // R4
  bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sub_q != '0) |-> $stable(txd));

  // R8
  back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
    (fin && buf_full) |=> !shift_empty);
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int OS      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fmt_load,
  input  logic [1:0]        len_sel,
  input  logic              par_off,
  input  logic              par_even,
  input  logic              stop_two,
  input  logic              load_n,
  input  logic [DATA_W-1:0] din,
  output logic              txd,
  output logic              buf_empty,
  output logic              shift_empty
);
  localparam int MIN_LEN = DATA_W - 3;
  localparam int FRAME_W = DATA_W + 2;
  localparam int CNT_W   = $clog2(OS * (DATA_W + 4) + 1);

  tx_fmt_t             fmt_q;
  logic [DATA_W-1:0]   buf_q;
  logic                buf_empty_q;
  logic                take;
  logic [FRAME_W-1:0]  frame;
  logic [CNT_W-1:0]    ticks;

  tx_fmt_reg u_fmt (
    .clk(clk), .rst(rst), .fmt_load(fmt_load), .len_sel(len_sel),
    .par_off(par_off), .par_even(par_even), .stop_two(stop_two), .fmt_q(fmt_q)
  );

  tx_buffer #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst(rst), .load_n(load_n), .din(din), .take(take),
    .buf_q(buf_q), .buf_empty_q(buf_empty_q)
  );

  tx_frame_pack #(.DATA_W(DATA_W), .MIN_LEN(MIN_LEN), .OS(OS),
                  .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_pack (
    .fmt(fmt_q), .data(buf_q), .frame(frame), .ticks(ticks)
  );

  tx_shifter #(.FRAME_W(FRAME_W), .OS(OS), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst(rst), .buf_full(!buf_empty_q), .frame(frame), .ticks(ticks),
    .take(take), .txd(txd), .shift_empty(shift_empty)
  );

  assign buf_empty = buf_empty_q;
endmodule

// File: tb/sim_uart_tx_core.sv
module sim_uart_tx_core;
  localparam int CLK_P = 10;
  localparam int NVEC  = 8;
  // {len_sel, par_off, par_even, stop_two, din}
  localparam logic [12:0] VEC [NVEC] = '{
    {2'b11, 1'b1, 1'b0, 1'b0, 8'hA5},
    {2'b11, 1'b0, 1'b1, 1'b1, 8'h3C},
    {2'b11, 1'b0, 1'b0, 1'b0, 8'h3C},
    {2'b00, 1'b1, 1'b0, 1'b1, 8'hFF},
    {2'b00, 1'b0, 1'b1, 1'b0, 8'hE6},
    {2'b01, 1'b0, 1'b0, 1'b1, 8'h2D},
    {2'b10, 1'b1, 1'b0, 1'b1, 8'h55},
    {2'b10, 1'b0, 1'b1, 1'b0, 8'hFF}
  };

  logic clk = 0, rst = 1, fmt_load = 0, par_off = 1, par_even = 0, stop_two = 0, load_n = 1;
  logic [1:0] len_sel = 2'b11;
  logic [7:0] din = 8'h00;
  logic txd, buf_empty, shift_empty;

  int checks = 0, fails = 0;
  logic [11:0] eb;
  int et;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  uart_tx_core u0 (
    .clk(clk), .rst(rst), .fmt_load(fmt_load), .len_sel(len_sel), .par_off(par_off),
    .par_even(par_even), .stop_two(stop_two), .load_n(load_n), .din(din),
    .txd(txd), .buf_empty(buf_empty), .shift_empty(shift_empty)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic calc(input logic [1:0] ln, input logic po, input logic pe,
                      input logic s2, input logic [7:0] d);
    int dl;
    logic p;
    dl = 5 + int'(ln);
    eb = '1;
    eb[0] = 1'b0;
    p = 1'b0;
    for (int i = 0; i < dl; i++) begin
      eb[1+i] = d[i];
      p = p ^ d[i];
    end
    if (!po) eb[1+dl] = pe ? p : ~p;
    et = 16 * (1 + dl + (po ? 0 : 1)) + (!s2 ? 16 : (dl == 5 ? 24 : 32));
  endtask

  task automatic set_fmt(input logic [1:0] ln, input logic po, input logic pe, input logic s2);
    @(negedge clk);
    len_sel = ln; par_off = po; par_even = pe; stop_two = s2; fmt_load = 1;
    @(negedge clk);
    fmt_load = 0;
  endtask

  task automatic load_byte(input logic [7:0] d);
    @(negedge clk);
    din = d; load_n = 0;
    @(negedge clk);
    load_n = 1;
    chk(buf_empty == 0, "R2 buf_empty after load", buf_empty, 0);
  endtask

  // mode 0: plain; 1: format change at clock 40; 2: second load at clock 20
  task automatic watch(input int start_k, input int mode, input logic [7:0] d2);
    for (int k = start_k; k < et; k++) begin
      @(negedge clk);
      chk(txd == eb[k/16], "R4 R5 R6 txd bit", txd, eb[k/16]);
      if (k == 0) begin
        chk(buf_empty == 1, "R3 buf_empty at transfer", buf_empty, 1);
        chk(shift_empty == 0, "R3 shift_empty at transfer", shift_empty, 0);
      end
      if (k == et - 1) chk(shift_empty == 0, "R6 busy on last stop clock", shift_empty, 0);
      if (mode == 1 && k == 40) begin
        len_sel = 2'b00; par_off = 1; stop_two = 0; fmt_load = 1;
      end
      if (mode == 1 && k == 41) fmt_load = 0;
      if (mode == 2 && k == 20) begin din = d2; load_n = 0; end
      if (mode == 2 && k == 21) begin
        chk(buf_empty == 0, "R2 buf_empty after second load", buf_empty, 0);
        load_n = 1;
      end
    end
    @(negedge clk);
    if (mode == 2) begin
      chk(shift_empty == 0, "R8 no idle between characters", shift_empty, 0);
      chk(txd == 0, "R8 next start bit at once", txd, 0);
      chk(buf_empty == 1, "R8 buffer freed", buf_empty, 1);
    end else begin
      chk(shift_empty == 1, "R7 shift_empty after stop", shift_empty, 1);
      chk(txd == 1, "R7 txd idle high", txd, 1);
      chk(buf_empty == 1, "R7 buffer empty", buf_empty, 1);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    chk(0, "watchdog", 0, 1);
    if (!done) begin
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(txd == 1, "R1 txd after reset", txd, 1);
    chk(buf_empty == 1, "R1 buf_empty after reset", buf_empty, 1);
    chk(shift_empty == 1, "R1 shift_empty after reset", shift_empty, 1);

    // R1 default format: 8 bits, no parity, one stop bit
    len_sel = 2'b00; par_off = 0; stop_two = 1;
    calc(2'b11, 1, 0, 0, 8'h96);
    load_byte(8'h96);
    watch(0, 0, 8'h00);

    // table walk: R4 R5 R6 R10
    for (int v = 0; v < NVEC; v++) begin
      set_fmt(VEC[v][12:11], VEC[v][10], VEC[v][9], VEC[v][8]);
      calc(VEC[v][12:11], VEC[v][10], VEC[v][9], VEC[v][8], VEC[v][7:0]);
      load_byte(VEC[v][7:0]);
      watch(0, 0, 8'h00);
    end

    // R9 inputs without strobe are ignored
    set_fmt(2'b01, 0, 1, 0);
    len_sel = 2'b11; par_off = 1; par_even = 0; stop_two = 1;
    calc(2'b01, 0, 1, 0, 8'h2A);
    load_byte(8'h2A);
    watch(0, 0, 8'h00);

    // R9 format change mid-character applies to next character only
    set_fmt(2'b11, 0, 0, 1);
    calc(2'b11, 0, 0, 1, 8'hC3);
    load_byte(8'hC3);
    watch(0, 1, 8'h00);
    calc(2'b00, 1, 0, 0, 8'hF3);
    load_byte(8'hF3);
    watch(0, 0, 8'h00);

    // R8 back-to-back characters
    set_fmt(2'b10, 0, 1, 0);
    calc(2'b10, 0, 1, 0, 8'h11);
    load_byte(8'h11);
    watch(0, 2, 8'h6E);
    calc(2'b10, 0, 1, 0, 8'h6E);
    watch(1, 0, 8'h00);

    // R1 reset in the middle of a character
    set_fmt(2'b11, 0, 1, 1);
    load_byte(8'h00);
    repeat (50) @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk(txd == 1, "R1 txd after mid-frame reset", txd, 1);
    chk(buf_empty == 1, "R1 buf_empty after mid-frame reset", buf_empty, 1);
    chk(shift_empty == 1, "R1 shift_empty after mid-frame reset", shift_empty, 1);
    calc(2'b11, 1, 0, 0, 8'h81);
    load_byte(8'h81);
    watch(0, 0, 8'h00);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule